// File: doc/BRIEF.md
# Sequence Table with Key-Guarded Write Lock

This block stores a table of command sequences for a serial-memory sequence engine. The table has sixteen sequences of four 32-bit words each, and each sequence occupies four consecutive word slots. Software writes and reads the table through a single-cycle 32-bit register bus. The sequence engine reads any word through a separate fetch port, using a sequence number and a word number.

Writes to the table take effect only while the table is unlocked. Changing the lock state takes two bus writes. The first writes a magic key to the key register. The very next bus write must go to the lock-control register, and it must request either lock or unlock. A status bit in the lock-control register reads back the current lock state.

Top module: `seqtab_keylock`

## Requirements
- R1: After reset the table is locked, the status read of the lock-control register (offset 0x304) returns 1 in bit 0, and every table word reads as zero on both the bus and the fetch port.
- R2: The table word for sequence s and word w sits at bus offset 0x310 + (s*4 + w)*4. Sequence 0 word 0 is at 0x310 and sequence 15 word 3 is at 0x40C.
- R3: While the table is locked, bus writes to table words are dropped and the stored contents stay unchanged.
- R4: Writing 0x5AF05AF0 to the key register (offset 0x300), and then writing a value with bit 1 set and bit 0 clear to the lock-control register as the next bus write, unlocks the table. Table writes after that are stored.
- R5: Writing the key, and then writing a value with bit 0 set to the lock-control register as the next bus write, locks the table.
- R6: A lock-control write is ignored if the bus write just before it was not the correct key written to the key register. That covers three cases: no key write at all, a wrong key value, and another write in between. Bus reads between the key write and the lock-control write do not cancel the key.
- R7: One key write allows only one lock-control write. A second lock-control write needs a fresh key write.
- R8: If a keyed lock-control write sets both bit 0 and bit 1, the lock request wins and the table ends up locked.
- R9: Bus read data appears on regRdData in the cycle after the read strobe. The key register, unmapped offsets and offsets beyond the table end (0x410 and up) all read as zero.
- R10: The fetch port returns the stored word for fetchSeq/fetchWord in the same cycle, without a register stage. A table write shows on the fetch port in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Bus write strobe |
| regRdEn | input | 1 | Bus read strobe |
| regAddr | input | 12 | Bus byte address, word aligned |
| regWrData | input | 32 | Bus write data |
| regRdData | output | 32 | Bus read data, valid the cycle after regRdEn |
| fetchSeq | input | 4 | Sequence number for the fetch port |
| fetchWord | input | 2 | Word number within the sequence |
| fetchData | output | 32 | Fetched table word |

## Verification
The bench builds the block with its default parameters: sixteen four-word sequences, a 12-bit address and the standard key and offsets. With these values the first and last table slots (0x310 and 0x40C) and the first address past the table (0x410) can all be reached directly from the bus. The full table is small enough to fill with a distinct pattern per word and to sweep completely through the fetch port. The lock protocol's near-misses are driven explicitly: no key, a wrong key, an intervening table write, an intervening read, a reused key and a both-bits request.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_TABLE  = 2'd1,
    SEL_STATUS = 2'd2
  } rd_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    tableWe;
    logic    rdEn;
    rd_sel_e rdSel;
  } seqtab_strb_t;

endpackage

// File: rtl/seqtab_lock_ctrl.sv
module seqtab_lock_ctrl
  import seqtab_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          TOTAL_WORDS = 64,
  parameter int          KEY_OFFS    = 'h300,
  parameter int          LOCK_OFFS   = 'h304,
  parameter int          TABLE_OFFS  = 'h310,
  parameter logic [DATA_W-1:0] KEY_VALUE = 32'h5AF0_5AF0,
  localparam int         IDX_W       = $clog2(TOTAL_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output seqtab_strb_t      strb,
  output logic [IDX_W-1:0]  tableIdx,
  output logic              locked,
  output logic              keyArmed
);

  localparam logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'(KEY_OFFS);
  localparam logic [ADDR_W-1:0] LOCK_ADDR  = ADDR_W'(LOCK_OFFS);
  localparam logic [ADDR_W-1:0] TABLE_ADDR = ADDR_W'(TABLE_OFFS);
  localparam logic [ADDR_W-1:0] TABLE_SPAN = ADDR_W'(TOTAL_WORDS * 4);
  localparam int LOCK_BIT   = 0;
  localparam int UNLOCK_BIT = 1;

  logic [ADDR_W-1:0] tableOffs;
  logic aligned, isKeyReg, isLockReg, isTable, keyGood;

  assign aligned   = (regAddr[1:0] == 2'b00);
  assign isKeyReg  = (regAddr == KEY_ADDR);
  assign isLockReg = (regAddr == LOCK_ADDR);
  // below-base addresses wrap to large values and miss the span
  assign tableOffs = regAddr - TABLE_ADDR;
  assign isTable   = aligned && (tableOffs < TABLE_SPAN);
  assign tableIdx  = tableOffs[IDX_W+1:2];
  assign keyGood   = regWrEn && isKeyReg && (regWrData == KEY_VALUE);

  always_comb begin
    strb.tableWe = regWrEn && isTable && !locked;
    strb.rdEn    = regRdEn;
    if (isTable)        strb.rdSel = SEL_TABLE;
    else if (isLockReg) strb.rdSel = SEL_STATUS;
    else                strb.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked   <= 1'b1;
      keyArmed <= 1'b0;
    end else if (regWrEn) begin
      keyArmed <= keyGood;
      if (isLockReg && keyArmed) begin
        if (regWrData[LOCK_BIT])        locked <= 1'b1;
        else if (regWrData[UNLOCK_BIT]) locked <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/seqtab_store.sv
module seqtab_store
  import seqtab_pkg::*;
#(
  parameter int  DATA_W      = 32,
  parameter int  SEQ_COUNT   = 16,
  parameter int  SEQ_WORDS   = 4,
  localparam int TOTAL_WORDS = SEQ_COUNT * SEQ_WORDS,
  localparam int IDX_W       = $clog2(TOTAL_WORDS),
  localparam int SEQ_W       = $clog2(SEQ_COUNT),
  localparam int WORD_W      = $clog2(SEQ_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqtab_strb_t      strb,
  input  logic [IDX_W-1:0]  tableIdx,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              locked,
  input  logic [SEQ_W-1:0]  fetchSeq,
  input  logic [WORD_W-1:0] fetchWord,
  output logic [DATA_W-1:0] fetchData,
  output logic [DATA_W-1:0] regRdData
);

  logic [DATA_W-1:0] wordQ [TOTAL_WORDS];

  for (genvar gi = 0; gi < TOTAL_WORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)
        wordQ[gi] <= '0;
      else if (strb.tableWe && (tableIdx == IDX_W'(gi)))
        wordQ[gi] <= regWrData;
    end
  end

  assign fetchData = wordQ[{fetchSeq, fetchWord}];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_TABLE:  regRdData <= wordQ[tableIdx];
        SEL_STATUS: regRdData <= {{(DATA_W-1){1'b0}}, locked};
        default:    regRdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/seqtab_keylock.sv
module seqtab_keylock
  import seqtab_pkg::*;
#(
  parameter int          SEQ_COUNT  = 16,
  parameter int          SEQ_WORDS  = 4,
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          KEY_OFFS   = 'h300,
  parameter int          LOCK_OFFS  = 'h304,
  parameter int          TABLE_OFFS = 'h310,
  parameter logic [DATA_W-1:0] KEY_VALUE = 32'h5AF0_5AF0,
  localparam int         TOTAL_WORDS = SEQ_COUNT * SEQ_WORDS,
  localparam int         IDX_W      = $clog2(TOTAL_WORDS),
  localparam int         SEQ_W      = $clog2(SEQ_COUNT),
  localparam int         WORD_W     = $clog2(SEQ_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [SEQ_W-1:0]  fetchSeq,
  input  logic [WORD_W-1:0] fetchWord,
  output logic [DATA_W-1:0] fetchData
);

  seqtab_strb_t     strb;
  logic [IDX_W-1:0] tableIdx;
  logic             locked;
  logic             keyArmed;

  seqtab_lock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOTAL_WORDS(TOTAL_WORDS),
    .KEY_OFFS(KEY_OFFS), .LOCK_OFFS(LOCK_OFFS), .TABLE_OFFS(TABLE_OFFS),
    .KEY_VALUE(KEY_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .strb(strb),
    .tableIdx(tableIdx), .locked(locked), .keyArmed(keyArmed)
  );

  seqtab_store #(
    .DATA_W(DATA_W), .SEQ_COUNT(SEQ_COUNT), .SEQ_WORDS(SEQ_WORDS)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .tableIdx(tableIdx),
    .regWrData(regWrData), .locked(locked), .fetchSeq(fetchSeq),
    .fetchWord(fetchWord), .fetchData(fetchData), .regRdData(regRdData)
  );

endmodule

// File: rtl/seqtab_keylock_chk.sv
module seqtab_keylock_chk #(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          SEQ_W     = 4,
  parameter int          WORD_W    = 2,
  parameter int          KEY_OFFS  = 'h300,
  parameter int          LOCK_OFFS = 'h304,
  parameter logic [DATA_W-1:0] KEY_VALUE = 32'h5AF0_5AF0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [SEQ_W-1:0]  fetchSeq,
  input logic [WORD_W-1:0] fetchWord,
  input logic [DATA_W-1:0] fetchData,
  input logic              locked,
  input logic              keyArmed
);

  localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(KEY_OFFS);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_OFFS);

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (locked && regWrEn ##1 ($stable(fetchSeq) && $stable(fetchWord))) |-> $stable(fetchData));

  assert_unlock_keyed_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(regWrEn && regAddr == LOCK_ADDR && keyArmed &&
                            regWrData[1] && !regWrData[0]));

  assert_lock_keyed_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(regWrEn && regAddr == LOCK_ADDR && keyArmed && regWrData[0]));

  assert_key_single_use_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !(regAddr == KEY_ADDR && regWrData == KEY_VALUE)) |=> !keyArmed);

  assert_key_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == KEY_ADDR) |=> (regRdData == '0));

  assert_status_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == LOCK_ADDR) |=> (regRdData == {{(DATA_W-1){1'b0}}, $past(locked)}));

endmodule

bind seqtab_keylock seqtab_keylock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .WORD_W(WORD_W),
  .KEY_OFFS(KEY_OFFS), .LOCK_OFFS(LOCK_OFFS), .KEY_VALUE(KEY_VALUE)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .fetchSeq(fetchSeq), .fetchWord(fetchWord), .fetchData(fetchData),
  .locked(locked), .keyArmed(keyArmed)
);

// File: tb/seqtab_keylock_tb.sv
module seqtab_keylock_tb;

  localparam logic [11:0] A_KEY  = 12'h300;
  localparam logic [11:0] A_LOCK = 12'h304;
  localparam logic [11:0] A_TAB  = 12'h310;
  localparam logic [31:0] KEY    = 32'h5AF0_5AF0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  fetchSeq = '0;
  logic [1:0]  fetchWord = '0;
  logic [31:0] fetchData;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seqtab_keylock u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fetchSeq(fetchSeq), .fetchWord(fetchWord), .fetchData(fetchData)
  );

  function automatic logic [31:0] pat(int i);
    return {8'hA5, 8'(i), 8'(i ^ 8'h3C), ~8'(i)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic fetch(int i, output logic [31:0] d);
    fetchSeq = 4'(i / 4); fetchWord = 2'(i % 4);
    #1 d = fetchData;
  endtask

  task automatic sendLockCmd(logic [31:0] cmd);
    busWrite(A_KEY, KEY);
    busWrite(A_LOCK, cmd);
  endtask

  task automatic checkStatus(string tag, logic exp);
    logic [31:0] d;
    busRead(A_LOCK, d);
    check(tag, d, {31'b0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int bad = 0;
    checkStatus("R1 status after reset", 1'b1);
    for (int i = 0; i < 64; i++) begin
      fetch(i, d);
      if (d !== 32'h0) bad++;
    end
    check("R1 fetch words zero count", 32'(bad), 32'h0);
    busRead(A_TAB + 12'h0FC, d);
    check("R1 bus read last word zero", d, 32'h0);
  endtask

  task automatic t_locked_drop();
    logic [31:0] d;
    busWrite(A_TAB + 12'h014, 32'hDEAD_BEEF);
    fetch(5, d);
    check("R3 locked write dropped", d, 32'h0);
  endtask

  task automatic t_unlock_fill();
    logic [31:0] d;
    int bad = 0;
    sendLockCmd(32'h2);
    checkStatus("R4 unlocked status", 1'b0);
    for (int i = 0; i < 64; i++) busWrite(A_TAB + 12'(i * 4), pat(i));
    for (int i = 0; i < 64; i++) begin
      fetch(i, d);
      if (d !== pat(i)) begin
        bad++;
        $display("FAIL R2 fetch word %0d actual=%h expected=%h", i, d, pat(i));
      end
    end
    check("R2 full table fetch mismatches", 32'(bad), 32'h0);
    busRead(12'h310, d);
    check("R2 seq0 word0 bus", d, pat(0));
    busRead(12'h40C, d);
    check("R2 seq15 word3 bus", d, pat(63));
    busRead(12'h310 + 12'((7 * 4 + 2) * 4), d);
    check("R2 seq7 word2 bus", d, pat(30));
  endtask

  task automatic t_fetch_timing();
    logic [31:0] d;
    fetch(9, d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_TAB + 12'h024; regWrData = 32'h1234_5678;
    #1 check("R10 fetch before write edge", fetchData, pat(9));
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R10 fetch after write edge", fetchData, 32'h1234_5678);
    busWrite(A_TAB + 12'h024, pat(9));
  endtask

  task automatic t_lock();
    logic [31:0] d;
    sendLockCmd(32'h1);
    checkStatus("R5 locked status", 1'b1);
    busWrite(A_TAB + 12'h040, 32'h0BAD_0BAD);
    fetch(16, d);
    check("R3 write while relocked dropped", d, pat(16));
  endtask

  task automatic t_bad_sequences();
    logic [31:0] d;
    busWrite(A_LOCK, 32'h2);
    checkStatus("R6 no key ignored", 1'b1);
    busWrite(A_KEY, 32'h5AF0_5AF1);
    busWrite(A_LOCK, 32'h2);
    checkStatus("R6 wrong key ignored", 1'b1);
    busWrite(A_KEY, KEY);
    busWrite(A_TAB, 32'hFFFF_0000);
    busWrite(A_LOCK, 32'h2);
    checkStatus("R6 intervening write ignored", 1'b1);
    fetch(0, d);
    check("R6 intervening locked write dropped", d, pat(0));
    busWrite(A_KEY, KEY);
    busRead(A_TAB, d);
    busWrite(A_LOCK, 32'h2);
    checkStatus("R6 read keeps key", 1'b0);
  endtask

  task automatic t_single_use();
    busWrite(A_LOCK, 32'h1);
    checkStatus("R7 reused key ignored", 1'b0);
    busWrite(A_KEY, KEY);
    busWrite(A_LOCK, 32'h0);
    busWrite(A_LOCK, 32'h1);
    checkStatus("R7 key consumed by no-op command", 1'b0);
    sendLockCmd(32'h3);
    checkStatus("R8 both bits lock", 1'b1);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    busRead(A_KEY, d);
    check("R9 key reg reads zero", d, 32'h0);
    busRead(12'h200, d);
    check("R9 unmapped reads zero", d, 32'h0);
    busRead(12'h410, d);
    check("R9 past table end reads zero", d, 32'h0);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = A_TAB + 12'h008;
    #1 check("R9 data not yet updated", regRdData, 32'h0);
    @(negedge clk);
    regRdEn = 1'b0;
    check("R9 data one cycle later", regRdData, pat(2));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_locked_drop();
    t_unlock_fill();
    t_fetch_timing();
    t_lock();
    t_bad_sequences();
    t_single_use();
    t_reads();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

endmodule